// File: doc/BRIEF.md
# Selectable Reference and Timebase Generator

This block runs directly from a 75 kHz crystal clock. It produces the comparison tick for a PLL phase detector at one of eight rates, and a 50 % duty 8 Hz timebase. A 3-bit select code picks the reference rate. The reference tick is a single-cycle pulse at the chosen rate.

The timebase can take over one general-purpose output pin. When it is enabled, the pin follows the square wave. Otherwise the pin follows a software data bit. The pin state is encoded as 1 = pull low and 0 = released.

An inhibit input freezes the reference counter. The timebase keeps running while the inhibit is asserted.

Top module: `ref_tbase_gen`

## Requirements
- R1: After a synchronous reset, ref_pulse, tb_wave and pin_low are all 0. A released pin is encoded as pin_low = 0.
- R2: The select code maps to a divide ratio N as follows: 0→75 (1 kHz), 1→25 (3 kHz), 2→15 (5 kHz), 3→24 (3.125 kHz), 4→12 (6.25 kHz), 5→6 (12.5 kHz), 6→5 (15 kHz), 7→3 (25 kHz). After reset, ref_pulse is high after clock edges N, 2N, 3N and so on.
- R3: ref_pulse is never high for two consecutive cycles.
- R4: If ref_sel differs at an edge e from its value at the previous edge, the counter restarts. ref_pulse is then 0 after edge e, and the next pulse comes after edge e+N for the new N.
- R5: tb_wave has a period of 9375 input cycles. It rises after edge 4687 following reset and falls after edge 9375, so it is low for 4687 cycles and high for 4688 cycles.
- R6: While tb_en is 0, pin_low after an edge equals port_bit sampled at that edge.
- R7: While tb_en is 1, pin_low after an edge equals tb_wave as it was before that edge, and port_bit has no effect.
- R8: While inhibit is 1, ref_pulse stays 0 and the reference count holds. When inhibit is released, counting resumes from the held count. tb_wave is unaffected by inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 75 kHz crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel | input | 3 | Reference rate select code |
| tb_en | input | 1 | Route the timebase to the output pin |
| port_bit | input | 1 | Data bit for the output pin (1 = pull low) |
| inhibit | input | 1 | Freezes the reference counter |
| ref_pulse | output | 1 | One-cycle reference tick |
| tb_wave | output | 1 | 8 Hz square wave |
| pin_low | output | 1 | Resolved pin state, 1 = pull low, 0 = released |

## Verification
The bench steps through every select code and switches codes in the middle of a count. A design that kept the old count, or that fired an early pulse off the stale limit, would show a pulse too soon. It holds inhibit in the middle of a count and expects the pulse to be delayed by exactly the inhibit length. A design that reset the count, or that also stalled the timebase, would then drift from the model. The timebase is run past its first rising and falling edges, which catches an off-by-one in the half-period split. The bench toggles port_bit while the timebase owns the pin to show that the data bit has no effect in that mode.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned NUM_RATES = 1 << SEL_W;

  // reference rate in units of 1/8 Hz, so non-integer kHz rates stay exact
  function automatic int unsigned rate_x8(input logic [SEL_W-1:0] code);
    case (code)
      3'd0: rate_x8 = 8000;
      3'd1: rate_x8 = 24000;
      3'd2: rate_x8 = 40000;
      3'd3: rate_x8 = 25000;
      3'd4: rate_x8 = 50000;
      3'd5: rate_x8 = 100000;
      3'd6: rate_x8 = 120000;
      default: rate_x8 = 200000;
    endcase
  endfunction

  function automatic int unsigned ref_ratio(input int unsigned xtal_hz,
                                            input logic [SEL_W-1:0] code);
    ref_ratio = (xtal_hz * 8) / rate_x8(code);
  endfunction

  function automatic int unsigned max_ratio(input int unsigned xtal_hz);
    max_ratio = 0;
    for (int i = 0; i < NUM_RATES; i++)
      if (ref_ratio(xtal_hz, SEL_W'(i)) > max_ratio)
        max_ratio = ref_ratio(xtal_hz, SEL_W'(i));
  endfunction
endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int unsigned XTAL_HZ = 75000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [rtg_pkg::SEL_W-1:0] sel,
  input  logic                      hold,
  output logic                      pulse
);
  localparam int unsigned MAXR = rtg_pkg::max_ratio(XTAL_HZ);
  localparam int unsigned CW   = $clog2(MAXR + 1);

  logic [rtg_pkg::SEL_W-1:0] sel_q;
  logic [CW-1:0]             cnt;
  logic [CW-1:0]             lim;
  logic                      at_lim;

  always_comb begin
    lim    = CW'(rtg_pkg::ref_ratio(XTAL_HZ, sel_q) - 1);
    at_lim = (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= sel;
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (sel != sel_q) begin
      sel_q <= sel;
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (hold) begin
      pulse <= 1'b0;
    end else begin
      pulse <= at_lim;
      cnt   <= at_lim ? '0 : cnt + 1'b1;
    end
  end

  // R3: a tick never lasts more than one cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  // R8: a frozen counter produces no tick
  a_r8_hold_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (hold && sel == sel_q) |=> (!pulse && cnt == $past(cnt)));
endmodule

// File: rtl/tb_divider.sv
module tb_divider #(
  parameter int unsigned DIV = 9375
) (
  input  logic clk,
  input  logic rst,
  output logic wave
);
  localparam int unsigned CW   = $clog2(DIV);
  localparam int unsigned HALF = DIV / 2;

  logic [CW-1:0] cnt;
  logic          wrap;
  logic          mid;

  always_comb begin
    wrap = (cnt == CW'(DIV - 1));
    mid  = (cnt == CW'(HALF - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap || mid) wave <= ~wave;
    end
  end

  // R5: rising edge lands at the half point, falling edge at the wrap
  a_r5_rise_at_half: assert property (@(posedge clk) disable iff (rst)
    $rose(wave) |-> (cnt == CW'(HALF)));
  a_r5_fall_at_wrap: assert property (@(posedge clk) disable iff (rst)
    $fell(wave) |-> (cnt == '0));
endmodule

// File: rtl/pin_mux.sv
module pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic tb_en,
  input  logic tb_wave,
  input  logic port_bit,
  output logic pin_low
);
  always_ff @(posedge clk) begin
    if (rst) pin_low <= 1'b0;
    else     pin_low <= tb_en ? tb_wave : port_bit;
  end

  // R6: data bit drives the pin when the timebase is off
  a_r6_pin_data: assert property (@(posedge clk) disable iff (rst)
    !tb_en |=> (pin_low == $past(port_bit)));
  // R7: timebase owns the pin when enabled
  a_r7_pin_wave: assert property (@(posedge clk) disable iff (rst)
    tb_en |=> (pin_low == $past(tb_wave)));
endmodule

// File: rtl/ref_tbase_gen.sv
module ref_tbase_gen #(
  parameter int unsigned XTAL_HZ = 75000,
  parameter int unsigned TB_HZ   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] ref_sel,
  input  logic       tb_en,
  input  logic       port_bit,
  input  logic       inhibit,
  output logic       ref_pulse,
  output logic       tb_wave,
  output logic       pin_low
);
  localparam int unsigned TB_DIV = XTAL_HZ / TB_HZ;

  ref_divider #(.XTAL_HZ(XTAL_HZ)) u_ref (
    .clk(clk), .rst(rst), .sel(ref_sel), .hold(inhibit), .pulse(ref_pulse)
  );

  tb_divider #(.DIV(TB_DIV)) u_tb (
    .clk(clk), .rst(rst), .wave(tb_wave)
  );

  pin_mux u_pin (
    .clk(clk), .rst(rst), .tb_en(tb_en), .tb_wave(tb_wave),
    .port_bit(port_bit), .pin_low(pin_low)
  );

  // R4: a select change kills any tick in the following cycle
  a_r4_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    (ref_sel != $past(ref_sel)) |=> !ref_pulse);
endmodule

// File: tb/tb_ref_tbase_gen.sv
module tb_ref_tbase_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] ref_sel = 3'd0;
  logic tb_en = 1'b0, port_bit = 1'b0, inhibit = 1'b0;
  logic ref_pulse, tb_wave, pin_low;

  ref_tbase_gen dut (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .tb_en(tb_en),
    .port_bit(port_bit), .inhibit(inhibit),
    .ref_pulse(ref_pulse), .tb_wave(tb_wave), .pin_low(pin_low)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  string ref_tag = "R2";
  int m_cnt = 0, m_tc = 0, m_sel = 0;
  bit m_pulse = 0, m_wave = 0, m_pin = 0, prev_pulse = 0, finished = 0;

  function automatic int ratio(int code);
    int t[8] = '{75, 25, 15, 24, 12, 6, 5, 3};
    return t[code];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycles, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; m_tc = 0; m_sel = ref_sel; m_pulse = 0; m_wave = 0; m_pin = 0;
    end else begin
      m_pin = tb_en ? m_wave : port_bit;
      if (int'(ref_sel) != m_sel) begin
        m_sel = ref_sel; m_cnt = 0; m_pulse = 0;
      end else if (inhibit) begin
        m_pulse = 0;
      end else begin
        m_cnt++;
        m_pulse = (m_cnt == ratio(m_sel));
        if (m_pulse) m_cnt = 0;
      end
      m_tc++;
      if (m_tc == 4687 || m_tc == 9375) m_wave = ~m_wave;
      if (m_tc == 9375) m_tc = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(ref_pulse == m_pulse, ref_tag, ref_pulse, m_pulse);
      check(tb_wave == m_wave, "R5", tb_wave, m_wave);
      check(pin_low == m_pin, tb_en ? "R7" : "R6", pin_low, m_pin);
      check(!(ref_pulse && prev_pulse), "R3", ref_pulse, 0);
      prev_pulse = ref_pulse;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    check(ref_pulse == 0 && tb_wave == 0 && pin_low == 0, "R1",
          {ref_pulse, tb_wave, pin_low}, 0);
    rst = 1'b0;
    run(200);
    for (int s = 1; s < 8; s++) begin
      ref_tag = "R4";
      ref_sel = 3'(s);
      run(2 * ratio(s) + 7);
    end
    ref_tag = "R4";
    ref_sel = 3'd0; run(40);
    ref_sel = 3'd2; run(50);
    ref_tag = "R8";
    ref_sel = 3'd3; run(10);
    inhibit = 1'b1; run(30);
    inhibit = 1'b0; run(60);
    inhibit = 1'b1; ref_sel = 3'd4; run(5);
    inhibit = 1'b0; run(40);
    ref_tag = "R2";
    for (int i = 0; i < 20; i++) begin
      port_bit = i[0]; run(3 + i);
    end
    tb_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      port_bit = ~port_bit; run(50);
    end
    tb_en = 1'b0; port_bit = 1'b1; run(10);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule